// File: doc/BRIEF.md
# Counter-Addressed Multiplexer Serializer

This block turns a small parallel word into a bit-serial stream without moving the stored bits. A holding register keeps the accepted word static. A free-running binary counter supplies the select code of a one-of-N multiplexer, and the multiplexer reads one stored bit per clock. The selected bit is registered onto a single serial line. A companion marker flags the cycle in which the first bit of each frame is on the line.

A new word is taken only at the frame boundary. It is captured on the clock edge at which the counter holds its last value, and all other load requests are dropped. As a result, the line never carries a mix of two words within one frame. The word width is a parameter and must be a power of two; the default is 4 bits with a 2-bit counter.

Top module: `mux_serializer`

## Requirements
- R1: While synchronous reset is high, and on the edge after it, `ser_out` and `frame_mark` are 0. Reset clears both the counter and the holding register to zero, so a frame that follows reset with no load carries all zeros.
- R2: The counter rises by one at every clock and wraps from WORD_W-1 to 0. Select code k chooses bit k of the held word. The bit chosen at an edge is on `ser_out` from that edge until the next one, which is one clock of latency.
- R3: `frame_mark` is 1 exactly in the cycles in which `ser_out` carries bit 0, so it is high in one cycle out of WORD_W.
- R4: `load_en` high at an edge where the counter equals WORD_W-1 copies `par_in` into the holding register. Bits 0 through WORD_W-1 of the new word then follow on `ser_out` in the next WORD_W cycles.
- R5: `load_en` high at an edge where the counter is not WORD_W-1 is ignored. The word on the line continues unchanged.
- R6: On the edge that captures a new word, `ser_out` takes the last bit (bit WORD_W-1) of the previous word.
- R7: Without a load, the held word is sent again frame after frame, unchanged.
- R8: A reset in the middle of a frame abandons that frame. The next frame starts at bit 0 of an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Request to take a new word |
| par_in | input | WORD_W | Parallel word to be sent |
| ser_out | output | 1 | Registered serial data line |
| frame_mark | output | 1 | High while bit 0 of a frame is on the line |

## Verification
Capturing a new word and sending the last bit of the old word happen on the same edge. The multiplexer reads the old register contents on the edge where the register takes the new ones. To provoke this, the bench raises the load request when its own phase count says the counter is at its final value. It then expects the old word's top bit in the cycle after that edge, followed by the new word's bit 0 together with the frame marker. A design that selects after capture, or that captures one cycle early or late, gives a torn or shifted frame at exactly this point.

// File: rtl/mux_serializer_pkg.sv
package mux_serializer_pkg;

  function automatic int sel_bits(input int width);
    return (width <= 2) ? 1 : $clog2(width);
  endfunction

endpackage

// File: rtl/ser_sel_counter.sv
module ser_sel_counter #(
  parameter int WORD_W = 4,
  localparam int SEL_W = mux_serializer_pkg::sel_bits(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [SEL_W-1:0] sel,
  output logic             at_last,
  output logic             at_first
);

  localparam logic [SEL_W-1:0] LAST = SEL_W'(WORD_W - 1);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= '0;
    else if (sel_q == LAST)
      sel_q <= '0;
    else
      sel_q <= sel_q + 1'b1;
  end

  assign sel      = sel_q;
  assign at_last  = (sel_q == LAST);
  assign at_first = (sel_q == '0);

endmodule

// File: rtl/ser_word_hold.sv
module ser_word_hold #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst)
      word_q <= '0;
    else if (take)
      word_q <= word_in;
  end

endmodule

// File: rtl/ser_bit_pick.sv
module ser_bit_pick #(
  parameter int WORD_W = 4,
  localparam int SEL_W = mux_serializer_pkg::sel_bits(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  input  logic              first,
  output logic              bit_q,
  output logic              mark_q
);

  logic [WORD_W-1:0] dec;
  logic [WORD_W-1:0] gated;
  logic              picked;

  for (genvar i = 0; i < WORD_W; i++) begin : g_lane
    assign dec[i]   = (sel == SEL_W'(i));
    assign gated[i] = dec[i] & word[i];
  end

  assign picked = |gated;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      bit_q  <= picked;
      mark_q <= first;
    end
  end

endmodule

// File: rtl/mux_serializer.sv
module mux_serializer #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [WORD_W-1:0] par_in,
  output logic              ser_out,
  output logic              frame_mark
);

  localparam int SEL_W = mux_serializer_pkg::sel_bits(WORD_W);

  logic [SEL_W-1:0]  sel;
  logic              at_last;
  logic              at_first;
  logic              take;
  logic [WORD_W-1:0] word_q;

  ser_sel_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .at_last  (at_last),
    .at_first (at_first)
  );

  assign take = load_en & at_last;

  ser_word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .word_in (par_in),
    .word_q  (word_q)
  );

  ser_bit_pick #(.WORD_W(WORD_W)) u_pick (
    .clk    (clk),
    .rst    (rst),
    .word   (word_q),
    .sel    (sel),
    .first  (at_first),
    .bit_q  (ser_out),
    .mark_q (frame_mark)
  );

endmodule

// File: rtl/mux_serializer_chk.sv
module mux_serializer_chk #(
  parameter int WORD_W = 4,
  localparam int SEL_W = mux_serializer_pkg::sel_bits(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              load_en,
  input logic [WORD_W-1:0] par_in,
  input logic              ser_out,
  input logic              frame_mark,
  input logic [SEL_W-1:0]  sel,
  input logic [WORD_W-1:0] word_q
);

  localparam logic [SEL_W-1:0] LAST = SEL_W'(WORD_W - 1);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!ser_out && !frame_mark && sel == '0)); // R1
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst) (sel != LAST) |=> (sel == $past(sel) + 1'b1)); // R2
  AST_SEL_WRAP: assert property (@(posedge clk) disable iff (rst) (sel == LAST) |=> (sel == '0)); // R2
  AST_LINE_BIT: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (ser_out == $past(word_q[sel]))); // R2
  AST_MARK_ON_FIRST: assert property (@(posedge clk) disable iff (rst) (sel == '0) |=> frame_mark); // R3
  AST_MARK_ONCE: assert property (@(posedge clk) disable iff (rst) (sel != '0) |=> !frame_mark); // R3
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst) (load_en && sel == LAST) |=> (word_q == $past(par_in))); // R4
  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst) !(load_en && sel == LAST) |=> $stable(word_q)); // R5

endmodule

bind mux_serializer mux_serializer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_en    (load_en),
  .par_in     (par_in),
  .ser_out    (ser_out),
  .frame_mark (frame_mark),
  .sel        (sel),
  .word_q     (word_q)
);

// File: tb/mux_serializer_test.sv
module mux_serializer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [3:0] par_in = 4'h0;
  logic       ser_out;
  logic       frame_mark;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  bit done = 1'b0;
  logic [3:0] cur = 4'h0;

  always #4 clk = ~clk;

  mux_serializer #(.WORD_W(4)) uut (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .par_in     (par_in),
    .ser_out    (ser_out),
    .frame_mark (frame_mark)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    edges++;
    #1;
  endtask

  task automatic align_to(input int p);
    while ((edges % 4) != p) step();
  endtask

  task automatic expect_frame(input logic [3:0] w, input string req);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(ser_out, w[i], req, $sformatf("bit %0d", i));
      chk(frame_mark, (i == 0), req, $sformatf("marker at bit %0d", i));
    end
  endtask

  // R1: reset state and all-zero frame afterwards
  task automatic t_reset();
    rst = 1'b1;
    load_en = 1'b0;
    step();
    step();
    chk(ser_out, 1'b0, "R1", "line in reset");
    chk(frame_mark, 1'b0, "R1", "marker in reset");
    rst = 1'b0;
    edges = 0;
    cur = 4'h0;
    expect_frame(4'h0, "R1");
  endtask

  // R4, R6, R2, R3: load at frame boundary
  task automatic t_load(input logic [3:0] w);
    align_to(3);
    load_en = 1'b1;
    par_in = w;
    step();
    load_en = 1'b0;
    par_in = ~w;
    chk(ser_out, cur[3], "R6", "old last bit on capture edge");
    cur = w;
    expect_frame(cur, "R4");
  endtask

  // R7: word repeats without a load
  task automatic t_repeat();
    align_to(0);
    expect_frame(cur, "R7");
    expect_frame(cur, "R7");
  endtask

  // R5: load requests at phases 0, 1 and 2 are dropped
  task automatic t_ignored(input logic [3:0] w);
    align_to(0);
    load_en = 1'b1;
    par_in = w;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(ser_out, cur[i], "R5", $sformatf("bit %0d during stray load", i));
    end
    load_en = 1'b0;
    step();
    chk(ser_out, cur[3], "R5", "bit 3 after stray load");
    expect_frame(cur, "R5");
  endtask

  // R8: reset in mid-frame
  task automatic t_mid_reset();
    align_to(2);
    rst = 1'b1;
    step();
    chk(ser_out, 1'b0, "R8", "line after mid-frame reset");
    chk(frame_mark, 1'b0, "R8", "marker after mid-frame reset");
    rst = 1'b0;
    edges = 0;
    cur = 4'h0;
    expect_frame(4'h0, "R8");
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load(4'b1011);
    t_repeat();
    t_load(4'b0110);
    t_ignored(4'b1001);
    t_load(4'b1000);
    t_load(4'b0001);
    t_mid_reset();
    t_load(4'b1111);
    t_ignored(4'b0000);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule